// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns a stream of 4-bit nibbles from a media access controller into the three-level serial signal for a 100 Mbit/s twisted-pair link. A frame arrives as nibbles qualified by a transmit-enable input. Every nibble is handled the same way, whatever frame field it belongs to. The only exception is the first byte of the frame, whose two nibbles are replaced by a start delimiter. Each nibble becomes a 5-bit code group. An end delimiter is appended once enable drops, and idle code groups fill the time between frames.

The code-group stream is shifted out one bit per clock, most significant bit first. Each bit is XORed with a free-running additive scrambler and then encoded as a three-level line symbol, so that a level change marks a one. The block runs from a single 125 MHz clock. It pulses a ready strobe once every five clocks, and on that cycle the caller presents the next nibble and its enable.

Top module: `fe_pcs_tx`

## Requirements
- R1: After reset `line_lvl` is 2'b00, and `nib_rdy` is high for exactly one clock in every five.
- R2: Each ready cycle on which `tx_en` is low while no frame is in progress emits the idle code group 11111.
- R3: The first nibble taken with `tx_en` high while idle is replaced by J (11000), and the nibble after it is replaced by K (10001). K is sent even if `tx_en` has already dropped.
- R4: Every other nibble taken with `tx_en` high is sent as its 4B/5B data group: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. The code groups are sent in the order the nibbles were taken, and the left bit of each group goes first.
- R5: The first ready cycle of a frame's data phase with `tx_en` low emits T (01101), and the next code group is always R (00111).
- R6: A nibble offered with `tx_en` high while R is being emitted is discarded. The next frame's J takes the place of the following nibble, so J/K never interrupts T/R.
- R7: Each serial bit is XORed with the key stream of an 11-bit LFSR with polynomial x^11 + x^9 + 1. The LFSR advances on every clock, through idle and frame bits alike, and starts from a nonzero seed.
- R8: On a 0 bit the line level holds. On a 1 bit it steps through the repeating cycle negative, zero, positive, zero. Positive is encoded 2'b01, zero 2'b00 and negative 2'b11, and 2'b10 never appears.
- R9: The first nonzero level after reset is negative (2'b11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Frame qualifier, sampled on ready cycles |
| tx_nib | input | 4 | Frame nibble, sampled on ready cycles |
| nib_rdy | output | 1 | High on the cycle the next nibble is taken |
| line_lvl | output | 2 | Three-level line symbol (01 +, 00 zero, 11 -) |

## Verification
The bench recovers the bit stream from the line levels alone. It learns the scrambler key from the first idle bits and descrambles everything after them, so a wrong tap, a stalled LFSR or an off-by-one bit order shows up as code groups that do not decode. Frames of one nibble and of many nibbles check that J/K replaces exactly two nibbles and that K still goes out when enable drops at once. A design that skipped K would decode as J followed by T. A back-to-back case raises enable during R: a design that let J cut into T/R, or that used the discarded nibble, would put a delimiter or a data group in the wrong place. The line monitor rejects any level change that skips zero or repeats a direction, and it checks that the first step goes negative.

// File: rtl/fe_tx_pkg.sv
// Shared constants, types and the 4B/5B data mapping for the transmit encoder.
package fe_tx_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;

    localparam logic [1:0] LVL_ZERO = 2'b00;
    localparam logic [1:0] LVL_POS  = 2'b01;
    localparam logic [1:0] LVL_NEG  = 2'b11;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_K    = 2'd1,
        FS_DATA = 2'd2,
        FS_R    = 2'd3
    } frm_state_t;

    // Map a data nibble to its 5-bit data code group.
    function automatic logic [CG_W-1:0] map_data(input logic [NIB_W-1:0] nib);
        logic [CG_W-1:0] cg;
        case (nib)
            4'h0: cg = 5'b11110;
            4'h1: cg = 5'b01001;
            4'h2: cg = 5'b10100;
            4'h3: cg = 5'b10101;
            4'h4: cg = 5'b01010;
            4'h5: cg = 5'b01011;
            4'h6: cg = 5'b01110;
            4'h7: cg = 5'b01111;
            4'h8: cg = 5'b10010;
            4'h9: cg = 5'b10011;
            4'hA: cg = 5'b10110;
            4'hB: cg = 5'b10111;
            4'hC: cg = 5'b11010;
            4'hD: cg = 5'b11011;
            4'hE: cg = 5'b11100;
            default: cg = 5'b11101;
        endcase
        return cg;
    endfunction
endpackage

// File: rtl/fe_tx_framer.sv
// Chooses the next code group on each load cycle: idle, J/K start delimiter,
// data, or T/R end delimiter. Assumes load is a one-cycle strobe that marks
// a code-group boundary; the nibble and enable are only looked at then.
module fe_tx_framer
    import fe_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] tx_nib,
    output logic [CG_W-1:0]  cg_o
);
    frm_state_t      state, state_nxt;
    logic [CG_W-1:0] last_cg;

    // Next code group and next state from the current state and the inputs.
    always_comb begin
        cg_o      = CG_IDLE;
        state_nxt = state;
        case (state)
            FS_IDLE: begin
                if (tx_en) begin
                    cg_o      = CG_J;
                    state_nxt = FS_K;
                end
            end
            FS_K: begin
                cg_o      = CG_K;
                state_nxt = FS_DATA;
            end
            FS_DATA: begin
                if (tx_en) begin
                    cg_o = map_data(tx_nib);
                end else begin
                    cg_o      = CG_T;
                    state_nxt = FS_R;
                end
            end
            default: begin
                cg_o      = CG_R;
                state_nxt = FS_IDLE;
            end
        endcase
    end

    // Advance the frame state and remember the emitted group on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FS_IDLE;
            last_cg <= CG_IDLE;
        end else if (load) begin
            state   <= state_nxt;
            last_cg <= cg_o;
        end
    end

    // R3: K always follows J.
    p_k_after_j_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && last_cg == CG_J) |-> (cg_o == CG_K));

    // R5: R always follows T.
    p_r_after_t_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && last_cg == CG_T) |-> (cg_o == CG_R));

    // R6: no J directly after T, since R must come in between.
    p_no_j_after_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && last_cg == CG_T) |-> (cg_o != CG_J));
endmodule

// File: rtl/fe_tx_serializer.sv
// Loads a code group every CG_W clocks and shifts it out MSB first.
// Assumes the group offered on the ready cycle is stable at that edge.
module fe_tx_serializer #(
    parameter int CG_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CG_W-1:0] cg_i,
    output logic            rdy_o,
    output logic            bit_o
);
    localparam int CNT_W = $clog2(CG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CG_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [CG_W-1:0]  shreg;

    assign rdy_o = (cnt == CNT_LAST);
    assign bit_o = shreg[CG_W-1];

    // Bit counter that wraps at a code-group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (rdy_o) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // Shift register: parallel load on ready, shift left otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '1;
        else if (rdy_o) shreg <= cg_i;
        else            shreg <= {shreg[CG_W-2:0], 1'b1};
    end

    // R1: ready never comes on two adjacent cycles.
    p_rdy_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);
endmodule

// File: rtl/fe_tx_scrambler.sv
// Additive scrambler: a free-running Fibonacci LFSR whose feedback bit is
// XORed onto each serial bit. Assumes SEED is nonzero.
module fe_tx_scrambler #(
    parameter int              LFSR_W = 11,
    parameter int              TAP    = 9,
    parameter logic [LFSR_W-1:0] SEED = 11'h5A3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic plain_i,
    output logic scr_o
);
    logic [LFSR_W-1:0] st;
    logic              key;

    assign key   = st[LFSR_W-1] ^ st[TAP-1];
    assign scr_o = plain_i ^ key;

    // Advance the LFSR on every clock, whatever the data.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEED;
        else        st <= {st[LFSR_W-2:0], key};
    end

    // R7: the LFSR never falls into the all-zero lock-up state.
    p_state_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0);
endmodule

// File: rtl/fe_tx_mlt3.sv
// Three-level line encoder: holds on 0, steps -,0,+,0 on 1.
// Assumes one input bit per clock; output is registered.
module fe_tx_mlt3
    import fe_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    output logic [1:0] lvl_o
);
    logic go_neg;

    // Step the level on a one, remembering which way to leave zero next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o  <= LVL_ZERO;
            go_neg <= 1'b1;
        end else if (bit_i) begin
            if (lvl_o == LVL_ZERO) begin
                lvl_o  <= go_neg ? LVL_NEG : LVL_POS;
                go_neg <= ~go_neg;
            end else begin
                lvl_o  <= LVL_ZERO;
            end
        end
    end

    // R8: a zero bit leaves the level unchanged.
    p_hold_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_i |=> $stable(lvl_o));

    // R8: from a nonzero level, a one returns to zero.
    p_back_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_i && lvl_o != LVL_ZERO) |=> (lvl_o == LVL_ZERO));

    // R8: from zero, a one leaves zero.
    p_leave_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_i && lvl_o == LVL_ZERO) |=> (lvl_o != LVL_ZERO));

    // R8: the unused encoding never appears.
    p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o != 2'b10);
endmodule

// File: rtl/fe_pcs_tx.sv
// Fast Ethernet transmit encoder top: framer -> serializer -> scrambler ->
// three-level encoder. Assumes a single 125 MHz clock and a caller that
// presents tx_en/tx_nib on every cycle where nib_rdy is high.
module fe_pcs_tx
    import fe_tx_pkg::*;
#(
    parameter int               LFSR_W = 11,
    parameter int               TAP    = 9,
    parameter logic [LFSR_W-1:0] SEED  = 11'h5A3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] tx_nib,
    output logic             nib_rdy,
    output logic [1:0]       line_lvl
);
    logic [CG_W-1:0] cg;
    logic            ser_bit;
    logic            scr_bit;

    fe_tx_framer u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (nib_rdy),
        .tx_en  (tx_en),
        .tx_nib (tx_nib),
        .cg_o   (cg)
    );

    fe_tx_serializer #(.CG_W(CG_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .cg_i  (cg),
        .rdy_o (nib_rdy),
        .bit_o (ser_bit)
    );

    fe_tx_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP), .SEED(SEED)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .plain_i (ser_bit),
        .scr_o   (scr_bit)
    );

    fe_tx_mlt3 u_mlt3 (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (scr_bit),
        .lvl_o (line_lvl)
    );
endmodule

// File: tb/sim_fe_pcs_tx.sv
module sim_fe_pcs_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [3:0] tx_nib = 4'h0;
    logic       nib_rdy;
    logic [1:0] line_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fe_pcs_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_nib(tx_nib),
        .nib_rdy(nib_rdy), .line_lvl(line_lvl)
    );

    // Monitor state: bit recovery, descrambling and group framing.
    logic [1:0]  prev_lvl;
    bit          last_pos;
    logic [1:0]  first_nz;
    int          mlt_bad;
    logic [10:0] kh;
    int          nbits;
    bit          d1, d2, started;
    logic [4:0]  acc;
    int          acc_n;
    logic [4:0]  cglog [0:1023];
    int          log_n;
    int          rdy_cnt;
    int          rdy_gap_bad;
    int          since_rdy;

    always @(negedge clk) begin
        logic b, key, p;
        if (!rst_n) begin
            prev_lvl = 2'b00; last_pos = 1'b1; first_nz = 2'b00; mlt_bad = 0;
            kh = '0; nbits = 0; d1 = 0; d2 = 0; started = 0; acc = '0; acc_n = 0;
            log_n = 0; rdy_cnt = 0; rdy_gap_bad = 0; since_rdy = -1;
        end else begin
            // line legality (R8, R9)
            if (line_lvl == 2'b10) mlt_bad++;
            if (line_lvl != prev_lvl) begin
                if (prev_lvl == 2'b00) begin
                    if (line_lvl != (last_pos ? 2'b11 : 2'b01)) mlt_bad++;
                    if (first_nz == 2'b00) first_nz = line_lvl;
                    last_pos = (line_lvl == 2'b01);
                end else if (line_lvl != 2'b00) mlt_bad++;
            end
            b = (line_lvl != prev_lvl);
            prev_lvl = line_lvl;
            // descramble (R7): learn key from the first idle bits
            if (nbits < 11) key = ~b;
            else            key = kh[10] ^ kh[8];
            kh = {kh[9:0], key};
            nbits++;
            p = b ^ key;
            // framing: MSB arrives two cycles after ready
            if (d2) begin
                started = 1; acc = {4'b0, p}; acc_n = 1;
            end else if (started) begin
                acc = {acc[3:0], p}; acc_n++;
            end
            if (started && acc_n == 5 && log_n < 1024) begin
                cglog[log_n] = acc; log_n++;
            end
            d2 = d1; d1 = nib_rdy;
            // ready spacing (R1)
            if (nib_rdy) begin
                if (since_rdy != -1 && since_rdy != 5) rdy_gap_bad++;
                rdy_cnt++; since_rdy = 1;
            end else if (since_rdy != -1) since_rdy++;
        end
    end

    function automatic logic [4:0] exp_data(input logic [3:0] n);
        logic [4:0] t [0:15];
        t[0]=5'b11110; t[1]=5'b01001; t[2]=5'b10100; t[3]=5'b10101;
        t[4]=5'b01010; t[5]=5'b01011; t[6]=5'b01110; t[7]=5'b01111;
        t[8]=5'b10010; t[9]=5'b10011; t[10]=5'b10110; t[11]=5'b10111;
        t[12]=5'b11010; t[13]=5'b11011; t[14]=5'b11100; t[15]=5'b11101;
        return t[n];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one nibble on the next ready cycle.
    task automatic drive(input bit en, input logic [3:0] n);
        @(negedge clk);
        while (!nib_rdy) @(negedge clk);
        tx_en = en; tx_nib = n;
    endtask

    logic [3:0] pool [0:63];

    task automatic send(input int base, input int len);
        for (int i = 0; i < len; i++) drive(1'b1, pool[base+i]);
    endtask

    task automatic find_start(input int from, output int idx);
        idx = from;
        while (idx < log_n && cglog[idx] == 5'b11111) idx++;
    endtask

    // Compare the logged groups of one frame from idx; returns the next index.
    task automatic check_seq(input int idx, input int base, input int len, input string req, output int nxt);
        int k = idx;
        int bad = 0;
        logic [4:0] e;
        int n = (len < 2) ? 4 : len + 2;
        for (int i = 0; i < n; i++) begin
            if (i == 0) e = 5'b11000;
            else if (i == 1) e = 5'b10001;
            else if (i == n-2) e = 5'b01101;
            else if (i == n-1) e = 5'b00111;
            else e = exp_data(pool[base+i]);
            if (k + i >= log_n || cglog[k+i] != e) begin
                if (bad == 0)
                    chk(1'b0, $sformatf("%s group %0d", req, i),
                        (k + i < log_n) ? int'(cglog[k+i]) : -1, int'(e));
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, req, 0, 0);
        nxt = k + n;
    endtask

    task automatic wait_groups(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 4'h0);
    endtask

    task automatic t_reset;
        chk(line_lvl == 2'b00, "R1 reset level", line_lvl, 0);
        @(negedge clk); #1 rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(rdy_cnt == 8 && rdy_gap_bad == 0, "R1 ready period", rdy_cnt, 8);
    endtask

    task automatic t_idle;
        int bad = 0;
        wait_groups(6);
        repeat (8) @(negedge clk);
        for (int i = 0; i < log_n; i++) if (cglog[i] != 5'b11111) bad++;
        chk(log_n > 8 && bad == 0, "R2 R7 idle groups", bad, 0);
        chk(first_nz == 2'b11, "R9 first step negative", first_nz, 2'b11);
    endtask

    task automatic t_long_frame;
        int mark, idx, nxt;
        for (int i = 0; i < 6; i++) pool[i] = 4'h5;
        pool[6] = 4'h5; pool[7] = 4'hD;
        for (int i = 0; i < 16; i++) pool[8+i] = 4'(i);
        mark = log_n;
        send(0, 24);
        wait_groups(6);
        repeat (8) @(negedge clk);
        find_start(mark, idx);
        check_seq(idx, 0, 24, "R3 R4 R5 R7 long frame", nxt);
        chk(nxt < log_n && cglog[nxt] == 5'b11111, "R2 idle after frame",
            (nxt < log_n) ? int'(cglog[nxt]) : -1, 5'h1f);
    endtask

    task automatic t_short_frames;
        int mark, idx, nxt;
        pool[30] = 4'hA;
        mark = log_n;
        send(30, 1);
        wait_groups(6);
        repeat (8) @(negedge clk);
        find_start(mark, idx);
        check_seq(idx, 30, 1, "R3 R6 one-nibble frame keeps K", nxt);
        pool[31] = 4'h3; pool[32] = 4'hC; pool[33] = 4'h0;
        mark = log_n;
        send(31, 3);
        wait_groups(6);
        repeat (8) @(negedge clk);
        find_start(mark, idx);
        check_seq(idx, 31, 3, "R4 R5 three-nibble frame", nxt);
    endtask

    task automatic t_back_to_back;
        int mark, idx, nxt, nxt2;
        pool[40] = 4'h5; pool[41] = 4'h5; pool[42] = 4'h7; pool[43] = 4'h9;
        pool[50] = 4'h5; pool[51] = 4'h5; pool[52] = 4'hE; pool[53] = 4'h1;
        mark = log_n;
        send(40, 4);
        drive(1'b0, 4'h0);   // T
        drive(1'b1, 4'hF);   // offered during R: discarded
        send(50, 4);
        wait_groups(6);
        repeat (8) @(negedge clk);
        find_start(mark, idx);
        check_seq(idx, 40, 4, "R5 first of back-to-back", nxt);
        check_seq(nxt, 50, 4, "R6 nibble during R dropped", nxt2);
        chk(nxt2 < log_n && cglog[nxt2] == 5'b11111, "R6 idle after second frame",
            (nxt2 < log_n) ? int'(cglog[nxt2]) : -1, 5'h1f);
    endtask

    task automatic t_line;
        chk(mlt_bad == 0, "R8 level steps only on one bits", mlt_bad, 0);
        chk(rdy_gap_bad == 0, "R1 ready spacing over run", rdy_gap_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_idle;
        t_long_frame;
        t_short_frames;
        t_back_to_back;
        t_line;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule